// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a seconds count that software can read, overwrite and compare against a programmed alarm value. A prescaler divides the system clock by a parameter to make a once-per-second tick, and each tick advances the count by one. The count wraps at 2^CNT_W. When the count arrives at the programmed match value, a raw alarm flag is set. A one-bit enable then gates that flag onto a level interrupt line.

Software reaches the block through a plain 32-bit register bus. Reads return data combinationally from the word address, and a write takes effect on the clock edge that samples the write strobe. The bus carries word addresses, so byte offset = 4 × word address. The top eight words of the 4 KB window return fixed identification bytes.

Top module: `sec_alarm_counter`

## Requirements
- R1: After reset, the count, match, last-loaded value, interrupt enable and raw flag all read 0, and `irq` is low.
- R2: Without a load, the count advances by one every TICKS_PER_SEC clocks and wraps modulo 2^CNT_W.
- R3: A write to word 2 (byte 0x08) sets the count to the written value and restarts the prescaler, so the next increment comes TICKS_PER_SEC clocks later. Word 2 reads back the last written value. Word 0 (byte 0x00) reads the count.
- R4: A write to word 1 (byte 0x04) stores the match value, and word 1 reads it back.
- R5: The raw flag is set on the edge where the count steps onto the match value. This includes a match below the current count, which is reached after the count wraps.
- R6: If a load writes the current match value, the raw flag is set on that write's edge. If a match write equals the count on that edge, the raw flag is also set on that edge.
- R7: Word 4 (byte 0x10) is the interrupt enable. Only data bit 0 is kept, and reads return 0 or 1.
- R8: Word 6 (byte 0x18) reads raw AND enable, and `irq` carries the same level. Word 5 (byte 0x14) reads the raw flag.
- R9: Any write to word 7 (byte 0x1C) clears the raw flag, whatever the data. An alarm event on the same edge takes priority over the clear.
- R10: Word 3 (byte 0x0C) always reads 1, and writes to it are ignored. Writes to words 0, 5 and 6 change nothing.
- R11: Word 7 reads as 0, and so does any word that is not mapped.
- R12: Words 0x3F8 to 0x3FF (bytes 0xFE0 to 0xFFC) read, in order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 10 | Word address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, raw flag AND enable |

## Verification
Register writes land on the rising edge that samples `bus_wr`. Read data follows the address in the same cycle. The bench therefore drives on the falling edge and samples 1 ns after it, which reads the state left by the most recent edge. After a load on edge E, the count holds its loaded value through edge E+TICKS_PER_SEC-1 and increments on edge E+TICKS_PER_SEC. The alarm flag and `irq` change on the edge where the count or the match changes. The bench counts edges from each load and reads just before and just after every expected transition.

// File: rtl/sac_pkg.sv
package sac_pkg;
   localparam int unsigned ADDR_W = 10;
   localparam int unsigned DATA_W = 32;

   localparam logic [ADDR_W-1:0] W_COUNT  = 10'h000;
   localparam logic [ADDR_W-1:0] W_MATCH  = 10'h001;
   localparam logic [ADDR_W-1:0] W_LOAD   = 10'h002;
   localparam logic [ADDR_W-1:0] W_CTRL   = 10'h003;
   localparam logic [ADDR_W-1:0] W_ENABLE = 10'h004;
   localparam logic [ADDR_W-1:0] W_RAW    = 10'h005;
   localparam logic [ADDR_W-1:0] W_MASKED = 10'h006;
   localparam logic [ADDR_W-1:0] W_CLEAR  = 10'h007;
   localparam logic [ADDR_W-4:0] W_IDBASE = 7'h7F;

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      case (idx)
         3'd0: id_byte = 8'h31;
         3'd1: id_byte = 8'h10;
         3'd2: id_byte = 8'h14;
         3'd3: id_byte = 8'h00;
         3'd4: id_byte = 8'h0D;
         3'd5: id_byte = 8'hF0;
         3'd6: id_byte = 8'h05;
         default: id_byte = 8'hB1;
      endcase
   endfunction
endpackage

// File: rtl/sac_prescaler.sv
module sac_prescaler #(
   parameter int unsigned TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (TICKS_PER_SEC == 1) begin : g_direct
         assign tick = !restart;
      end else begin : g_divide
         localparam int unsigned PW = $clog2(TICKS_PER_SEC);
         localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
               phase_q <= '0;
            end else if (phase_q == LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick = !restart && (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sac_core.sv
module sac_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_wr,
   input  logic             match_wr,
   input  logic             clear_wr,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] match_q,
   output logic             raw_q,
   output logic             evt
);
   logic [CNT_W-1:0] next_cnt;
   logic [CNT_W-1:0] next_match;
   logic             changed;

   always_comb begin
      if (load_wr)   next_cnt = wr_val;
      else if (tick) next_cnt = count_q + 1'b1;
      else           next_cnt = count_q;
      next_match = match_wr ? wr_val : match_q;
      changed    = load_wr || match_wr || tick;
      evt        = changed && (next_cnt == next_match);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         match_q <= '0;
         raw_q   <= 1'b0;
      end else begin
         count_q <= next_cnt;
         match_q <= next_match;
         if (evt)           raw_q <= 1'b1;
         else if (clear_wr) raw_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sac_regs.sv
module sac_regs
   import sac_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  count_q,
   input  logic [CNT_W-1:0]  match_q,
   input  logic              raw_q,
   output logic              load_wr,
   output logic              match_wr,
   output logic              clear_wr,
   output logic              enable_q,
   output logic [DATA_W-1:0] bus_rdata
);
   logic [DATA_W-1:0] loaded_q;
   logic              enable_wr;

   assign load_wr   = bus_wr && (bus_addr == W_LOAD);
   assign match_wr  = bus_wr && (bus_addr == W_MATCH);
   assign clear_wr  = bus_wr && (bus_addr == W_CLEAR);
   assign enable_wr = bus_wr && (bus_addr == W_ENABLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loaded_q <= '0;
         enable_q <= 1'b0;
      end else begin
         if (load_wr)   loaded_q <= bus_wdata;
         if (enable_wr) enable_q <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[ADDR_W-1:3] == W_IDBASE) begin
         bus_rdata = {24'h0, id_byte(bus_addr[2:0])};
      end else begin
         case (bus_addr)
            W_COUNT:  bus_rdata = DATA_W'(count_q);
            W_MATCH:  bus_rdata = DATA_W'(match_q);
            W_LOAD:   bus_rdata = loaded_q;
            W_CTRL:   bus_rdata = 32'd1;
            W_ENABLE: bus_rdata = {31'd0, enable_q};
            W_RAW:    bus_rdata = {31'd0, raw_q};
            W_MASKED: bus_rdata = {31'd0, raw_q & enable_q};
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter
   import sac_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned CNT_W         = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [9:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);
   generate
      if (TICKS_PER_SEC < 1) begin : g_bad_ticks
         $error("TICKS_PER_SEC must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
         $error("CNT_W must lie between 2 and 32");
      end
   endgenerate

   logic             tick;
   logic             load_wr;
   logic             match_wr;
   logic             clear_wr;
   logic             enable_q;
   logic             raw_q;
   logic             evt;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] match_q;
   logic [CNT_W-1:0] wr_val;

   assign wr_val = bus_wdata[CNT_W-1:0];

   sac_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(load_wr), .tick(tick)
   );

   sac_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(load_wr),
      .match_wr(match_wr), .clear_wr(clear_wr), .wr_val(wr_val),
      .count_q(count_q), .match_q(match_q), .raw_q(raw_q), .evt(evt)
   );

   sac_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .count_q(count_q), .match_q(match_q),
      .raw_q(raw_q), .load_wr(load_wr), .match_wr(match_wr),
      .clear_wr(clear_wr), .enable_q(enable_q), .bus_rdata(bus_rdata)
   );

   assign irq = raw_q & enable_q;
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             load_wr,
   input logic             match_wr,
   input logic             clear_wr,
   input logic             evt,
   input logic             raw_q,
   input logic             enable_q,
   input logic             irq,
   input logic [CNT_W-1:0] wr_val,
   input logic [CNT_W-1:0] count_q,
   input logic [CNT_W-1:0] match_q
);
   logic [CNT_W-1:0] cnt_inc;
   assign cnt_inc = count_q + 1'b1;

   AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      load_wr |=> (count_q == $past(wr_val)));  // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_wr && tick) |=> (count_q == $past(cnt_inc)));  // R2
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_wr && !tick) |=> $stable(count_q));  // R2
   AST_MATCH_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      match_wr |=> (match_q == $past(wr_val)));  // R4
   AST_RISE_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q) |-> (count_q == match_q));  // R5
   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> raw_q);  // R9
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_wr && !evt) |=> !raw_q);  // R9
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (enable_q && raw_q));  // R8
endmodule

bind sec_alarm_counter sac_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(load_wr),
   .match_wr(match_wr), .clear_wr(clear_wr), .evt(evt), .raw_q(raw_q),
   .enable_q(enable_q), .irq(irq), .wr_val(wr_val), .count_q(count_q),
   .match_q(match_q)
);

// File: tb/sec_alarm_counter_test.sv
module sec_alarm_counter_test;
   localparam int unsigned TPS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   sec_alarm_counter #(.TICKS_PER_SEC(TPS), .CNT_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rdchk(input string req, input logic [9:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      rdchk("R1 count", 10'h000, 0);
      rdchk("R1 match", 10'h001, 0);
      rdchk("R1 loaded", 10'h002, 0);
      rdchk("R1 enable", 10'h004, 0);
      rdchk("R1 raw", 10'h005, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      rdchk("R10 control", 10'h003, 1);
   endtask

   task automatic t_ident;
      logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++) begin
         rdchk("R12 id byte", 10'h3F8 + 10'(i), {24'd0, ids[i]});
      end
   endtask

   task automatic t_load_prescale;
      wr(10'h002, 1000);
      rdchk("R3 count after load", 10'h000, 1000);
      rdchk("R3 load readback", 10'h002, 1000);
      edges(3);
      rdchk("R3 prescaler restarted", 10'h000, 1000);
      edges(1);
      rdchk("R2 first increment", 10'h000, 1001);
      edges(4);
      rdchk("R2 second increment", 10'h000, 1002);
   endtask

   task automatic t_match_tick;
      wr(10'h002, 10);
      wr(10'h001, 12);
      rdchk("R4 match readback", 10'h001, 12);
      edges(5);
      rdchk("R5 not yet", 10'h005, 0);
      edges(1);
      rdchk("R5 raw on reach", 10'h005, 1);
      rdchk("R5 count at match", 10'h000, 12);
      rdchk("R8 masked off", 10'h006, 0);
      chk("R8 irq off", {31'd0, irq}, 0);
      wr(10'h004, 32'hFFFF_FFFF);
      rdchk("R7 enable bit0", 10'h004, 1);
      rdchk("R8 masked on", 10'h006, 1);
      chk("R8 irq on", {31'd0, irq}, 1);
      wr(10'h004, 32'hFFFF_FFFE);
      rdchk("R7 enable cleared", 10'h004, 0);
      chk("R8 irq gated", {31'd0, irq}, 0);
      wr(10'h004, 1);
      wr(10'h007, 0);
      rdchk("R9 clear with zero data", 10'h005, 0);
      chk("R9 irq drops", {31'd0, irq}, 0);
   endtask

   task automatic t_wrap;
      wr(10'h001, 1);
      wr(10'h007, 0);
      wr(10'h002, 32'hFFFF_FFFF);
      edges(4);
      rdchk("R2 wrap to zero", 10'h000, 0);
      rdchk("R5 no alarm at zero", 10'h005, 0);
      edges(4);
      rdchk("R5 count past wrap", 10'h000, 1);
      rdchk("R5 alarm after wrap", 10'h005, 1);
      chk("R8 irq after wrap", {31'd0, irq}, 1);
      wr(10'h007, 32'h1234_5678);
      rdchk("R9 clear any data", 10'h005, 0);
   endtask

   task automatic t_immediate;
      wr(10'h002, 100);
      rdchk("R6 no alarm on unequal load", 10'h005, 0);
      wr(10'h001, 100);
      rdchk("R6 match write equals count", 10'h005, 1);
      wr(10'h007, 32'hA5A5);
      rdchk("R9 cleared", 10'h005, 0);
      wr(10'h001, 500);
      rdchk("R6 no alarm on unequal match", 10'h005, 0);
      wr(10'h002, 500);
      rdchk("R6 load equals match", 10'h005, 1);
      wr(10'h007, 0);
   endtask

   task automatic t_ignored;
      wr(10'h002, 7000);
      wr(10'h000, 32'h55);
      rdchk("R10 count write ignored", 10'h000, 7000);
      wr(10'h003, 0);
      rdchk("R10 control still 1", 10'h003, 1);
      wr(10'h005, 32'hFFFF_FFFF);
      rdchk("R10 raw write ignored", 10'h005, 0);
      wr(10'h006, 32'hFFFF_FFFF);
      rdchk("R10 masked write ignored", 10'h006, 0);
      rdchk("R10 match unchanged", 10'h001, 500);
      rdchk("R11 clear word reads 0", 10'h007, 0);
      rdchk("R11 unmapped low", 10'h008, 0);
      rdchk("R11 unmapped high", 10'h3F7, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ident();
      t_load_prescale();
      t_match_tick();
      t_wrap();
      t_immediate();
      t_ignored();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule